// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recently used address translations. Each slot holds a virtual page number, a physical frame number, an address-space tag and a page-size shift, so pages of different sizes can share the array. A lookup compares the request against every slot in parallel. The response arrives one clock later and carries a hit flag, the slot index, the stored frame and shift, and the physical address that results.

Misses are filled from outside. An external table walker writes a complete entry through the insert port. The slot that receives it is chosen by a rotating victim pointer, and that pointer is visible on its own output. A maintenance port invalidates entries in one cycle. It can clear everything, clear by address-space tag, clear by address, or clear by address and tag together.

Top module: `xlate_cache`

## Requirements
- R1: A lookup with `lk_req` high returns its result on the next cycle with `lk_rsp_vld` high. `lk_hit` is 1 only if some valid slot holds `vpn == lk_va >> shift` and a tag equal to `lk_asid`. On a miss, `lk_hit` is 0.
- R2: When more than one valid slot matches a lookup, the lowest-numbered matching slot is reported in `lk_slot` and supplies the data.
- R3: On a hit, `lk_pa` equals `(frame << shift) | (lk_va & ((1 << shift) - 1))`. `lk_pfn` and `lk_shift` return the stored frame and shift.
- R4: An insert writes the slot named by `victim_idx`, whether or not that slot is valid, and then moves `victim_idx` up by one. After slot NUM_ENTRIES-1 it wraps to 0.
- R5: A lookup that hits the slot currently named by `victim_idx` moves the pointer up by one. A hit on any other slot, or a miss, leaves it unchanged.
- R6: A flush with `mnt_op` = 0 invalidates every slot and sets `victim_idx` to 0.
- R7: A flush with `mnt_op` = 1 invalidates every slot whose tag equals `mnt_asid` and leaves all other slots intact.
- R8: A flush with `mnt_op` = 2 invalidates every slot whose page (base `vpn << shift`, length `1 << shift`) contains `mnt_va`, whatever its tag.
- R9: A flush with `mnt_op` = 3 invalidates every slot that matches both `mnt_va` and `mnt_asid`, not only the first of them.
- R10: A flush completes in one cycle, and `mnt_done` pulses for one cycle after `mnt_req`. A lookup in the same cycle as a flush sees the contents from before the flush. An insert in the same cycle as a flush is dropped: nothing is written and the pointer does not move.
- R11: After reset no slot is valid, `victim_idx` is 0, and `lk_rsp_vld`, `lk_hit` and `mnt_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_rsp_vld | output | 1 | Lookup response valid (one cycle after request) |
| lk_hit | output | 1 | Lookup hit |
| lk_slot | output | IDX_W | Index of the hitting slot |
| lk_pfn | output | PFN_W | Stored frame number of the hit |
| lk_shift | output | SHIFT_W | Stored page-size shift of the hit |
| lk_pa | output | PA_W | Translated physical address |
| ins_req | input | 1 | Insert request |
| ins_vpn | input | VPN_W | Virtual page number to insert |
| ins_pfn | input | PFN_W | Frame number to insert |
| ins_asid | input | ASID_W | Address-space tag to insert |
| ins_shift | input | SHIFT_W | Page-size shift to insert |
| mnt_req | input | 1 | Flush request |
| mnt_op | input | 2 | Flush kind: 0 all, 1 by tag, 2 by address, 3 by address and tag |
| mnt_va | input | VA_W | Flush address |
| mnt_asid | input | ASID_W | Flush tag |
| mnt_done | output | 1 | Flush completion pulse |
| victim_idx | output | IDX_W | Current replacement pointer |

## Verification
The case that is hardest to reach from the ports is a hit on the exact slot the victim pointer names. Reaching it means steering the pointer back onto a known valid entry. The bench fills every slot so that the pointer wraps to slot 0, which already holds a known entry. It then looks up that entry and, after it, the next one, and confirms that a miss and a hit elsewhere leave the pointer where it is. Duplicate entries are built on purpose so that lowest-slot priority and the multi-match address-and-tag flush can both be observed. Flush, lookup and insert are also driven in the same cycle to check which of them takes effect.

// File: rtl/xlc_pkg.sv
package xlc_pkg;

  typedef enum logic [1:0] {
    FL_ALL       = 2'd0,
    FL_ASID      = 2'd1,
    FL_ADDR      = 2'd2,
    FL_ADDR_ASID = 2'd3
  } flush_op_e;

endpackage

// File: rtl/xlc_match.sv
module xlc_match #(
  parameter int VA_W    = 32,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int SHIFT_W = 5
) (
  input  logic               ent_vld,
  input  logic [VPN_W-1:0]   ent_vpn,
  input  logic [ASID_W-1:0]  ent_asid,
  input  logic [SHIFT_W-1:0] ent_shift,
  input  logic [VA_W-1:0]    lk_va,
  input  logic [ASID_W-1:0]  lk_asid,
  input  logic [VA_W-1:0]    mnt_va,
  input  logic [ASID_W-1:0]  mnt_asid,
  output logic               lk_hit,
  output logic               mnt_addr_hit,
  output logic               mnt_asid_hit
);

  logic [VA_W-1:0] lk_page;
  logic [VA_W-1:0] mnt_page;
  logic [VA_W-1:0] vpn_ext;

  always_comb begin
    vpn_ext      = VA_W'(ent_vpn);
    lk_page      = lk_va >> ent_shift;
    mnt_page     = mnt_va >> ent_shift;
    lk_hit       = ent_vld && (lk_page == vpn_ext) && (ent_asid == lk_asid);
    mnt_addr_hit = ent_vld && (mnt_page == vpn_ext);
    mnt_asid_hit = ent_vld && (ent_asid == mnt_asid);
  end

endmodule

// File: rtl/xlc_first_hit.sv
module xlc_first_hit #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req_vec,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);

  always_comb begin
    any   = |req_vec;
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_vec[i]) begin
        idx = IDX_W'(i);
      end
    end
    if (any) begin
      grant[idx] = 1'b1;
    end
  end

endmodule

// File: rtl/xlc_victim.sv
module xlc_victim #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = clr || adv;
    ptr_d  = ptr_q;
    if (clr) begin
      ptr_d = '0;
    end else if (adv) begin
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

  // R4
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);

  // R6
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr_q == '0));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + IDX_W'(1))));

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(ptr_q));

endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlc_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int MIN_SHIFT   = 12,
  parameter int ASID_W      = 8,
  parameter int SHIFT_W     = 5,
  parameter int VPN_W       = VA_W - MIN_SHIFT,
  parameter int PFN_W       = PA_W - MIN_SHIFT,
  parameter int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_req,
  input  logic [VA_W-1:0]    lk_va,
  input  logic [ASID_W-1:0]  lk_asid,
  output logic               lk_rsp_vld,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_slot,
  output logic [PFN_W-1:0]   lk_pfn,
  output logic [SHIFT_W-1:0] lk_shift,
  output logic [PA_W-1:0]    lk_pa,
  input  logic               ins_req,
  input  logic [VPN_W-1:0]   ins_vpn,
  input  logic [PFN_W-1:0]   ins_pfn,
  input  logic [ASID_W-1:0]  ins_asid,
  input  logic [SHIFT_W-1:0] ins_shift,
  input  logic               mnt_req,
  input  logic [1:0]         mnt_op,
  input  logic [VA_W-1:0]    mnt_va,
  input  logic [ASID_W-1:0]  mnt_asid,
  output logic               mnt_done,
  output logic [IDX_W-1:0]   victim_idx
);

  localparam int N = NUM_ENTRIES;

  // Slot storage: valid bits reset, payload does not
  logic [N-1:0]       vld_q;
  logic [N-1:0]       vld_d;
  logic [VPN_W-1:0]   vpn_q   [N];
  logic [PFN_W-1:0]   pfn_q   [N];
  logic [ASID_W-1:0]  asid_q  [N];
  logic [SHIFT_W-1:0] shift_q [N];

  logic [N-1:0] lk_match;
  logic [N-1:0] mnt_addr_m;
  logic [N-1:0] mnt_asid_m;
  logic [N-1:0] flush_sel;
  logic [N-1:0] wr_sel;
  logic [N-1:0] lk_grant;
  logic         lk_any;
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] ptr;
  logic         wr_en;
  logic         ptr_hit;
  logic         clr_all;
  flush_op_e    op;

  // Per-slot comparators
  for (genvar g = 0; g < N; g++) begin : g_slot
    xlc_match #(
      .VA_W   (VA_W),
      .VPN_W  (VPN_W),
      .ASID_W (ASID_W),
      .SHIFT_W(SHIFT_W)
    ) u_match (
      .ent_vld     (vld_q[g]),
      .ent_vpn     (vpn_q[g]),
      .ent_asid    (asid_q[g]),
      .ent_shift   (shift_q[g]),
      .lk_va       (lk_va),
      .lk_asid     (lk_asid),
      .mnt_va      (mnt_va),
      .mnt_asid    (mnt_asid),
      .lk_hit      (lk_match[g]),
      .mnt_addr_hit(mnt_addr_m[g]),
      .mnt_asid_hit(mnt_asid_m[g])
    );
  end

  xlc_first_hit #(
    .N    (N),
    .IDX_W(IDX_W)
  ) u_first (
    .req_vec(lk_match),
    .any    (lk_any),
    .idx    (lk_idx),
    .grant  (lk_grant)
  );

  xlc_victim #(
    .N    (N),
    .IDX_W(IDX_W)
  ) u_victim (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr_all),
    .adv  (wr_en || ptr_hit),
    .ptr  (ptr)
  );

  assign victim_idx = ptr;

  // Control decode
  always_comb begin
    op      = flush_op_e'(mnt_op);
    wr_en   = ins_req && !mnt_req;
    ptr_hit = lk_req && lk_any && (lk_idx == ptr);
    clr_all = mnt_req && (op == FL_ALL);
    wr_sel  = '0;
    if (wr_en) begin
      wr_sel[ptr] = 1'b1;
    end
    unique case (op)
      FL_ALL:       flush_sel = '1;
      FL_ASID:      flush_sel = mnt_asid_m;
      FL_ADDR:      flush_sel = mnt_addr_m;
      FL_ADDR_ASID: flush_sel = mnt_addr_m & mnt_asid_m;
      default:      flush_sel = '0;
    endcase
  end

  // Valid-bit next state
  always_comb begin
    vld_d = vld_q;
    if (mnt_req) begin
      vld_d = vld_q & ~flush_sel;
    end else begin
      vld_d = vld_q | wr_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (mnt_req || wr_en) begin
      vld_q <= vld_d;
    end
  end

  // Payload write, enabled per slot
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (wr_sel[i]) begin
        vpn_q[i]   <= ins_vpn;
        pfn_q[i]   <= ins_pfn;
        asid_q[i]  <= ins_asid;
        shift_q[i] <= ins_shift;
      end
    end
  end

  // Response path: select, form address, register
  logic [PFN_W-1:0]   sel_pfn;
  logic [SHIFT_W-1:0] sel_shift;
  logic [VA_W-1:0]    off_mask;
  logic [PA_W-1:0]    pa_d;
  logic               rsp_vld_q;
  logic               hit_q;
  logic [IDX_W-1:0]   slot_q;
  logic [PFN_W-1:0]   pfn_rq;
  logic [SHIFT_W-1:0] shift_rq;
  logic [PA_W-1:0]    pa_q;

  always_comb begin
    sel_pfn   = pfn_q[lk_idx];
    sel_shift = shift_q[lk_idx];
    off_mask  = ~({VA_W{1'b1}} << sel_shift);
    pa_d      = (PA_W'(sel_pfn) << sel_shift) | PA_W'(lk_va & off_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld_q <= 1'b0;
      hit_q     <= 1'b0;
      mnt_done  <= 1'b0;
    end else begin
      rsp_vld_q <= lk_req;
      hit_q     <= lk_req && lk_any;
      mnt_done  <= mnt_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= '0;
      pfn_rq   <= '0;
      shift_rq <= '0;
      pa_q     <= '0;
    end else if (lk_req && lk_any) begin
      slot_q   <= lk_idx;
      pfn_rq   <= sel_pfn;
      shift_rq <= sel_shift;
      pa_q     <= pa_d;
    end
  end

  assign lk_rsp_vld = rsp_vld_q;
  assign lk_hit     = hit_q;
  assign lk_slot    = slot_q;
  assign lk_pfn     = pfn_rq;
  assign lk_shift   = shift_rq;
  assign lk_pa      = pa_q;

  // R1
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rsp_vld |-> $past(lk_req));

  // R1
  hit_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_rsp_vld);

  // R2
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_grant));

  // R6
  flush_all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_req && mnt_op == 2'd0) |=> (vld_q == '0));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mnt_req |=> mnt_done);

  // R10
  no_insert_in_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mnt_req |=> ($countones(vld_q) <= $countones($past(vld_q))));

endmodule

// File: tb/xlate_cache_tb.sv
module xlate_cache_tb;
  import xlc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 16;

  logic        clk;
  logic        rst_n;
  logic        lk_req;
  logic [31:0] lk_va;
  logic [7:0]  lk_asid;
  logic        lk_rsp_vld;
  logic        lk_hit;
  logic [3:0]  lk_slot;
  logic [19:0] lk_pfn;
  logic [4:0]  lk_shift;
  logic [31:0] lk_pa;
  logic        ins_req;
  logic [19:0] ins_vpn;
  logic [19:0] ins_pfn;
  logic [7:0]  ins_asid;
  logic [4:0]  ins_shift;
  logic        mnt_req;
  logic [1:0]  mnt_op;
  logic [31:0] mnt_va;
  logic [7:0]  mnt_asid;
  logic        mnt_done;
  logic [3:0]  victim_idx;

  int n_checks;
  int n_fail;

  xlate_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid),
    .lk_rsp_vld(lk_rsp_vld), .lk_hit(lk_hit), .lk_slot(lk_slot),
    .lk_pfn(lk_pfn), .lk_shift(lk_shift), .lk_pa(lk_pa),
    .ins_req(ins_req), .ins_vpn(ins_vpn), .ins_pfn(ins_pfn),
    .ins_asid(ins_asid), .ins_shift(ins_shift),
    .mnt_req(mnt_req), .mnt_op(mnt_op), .mnt_va(mnt_va), .mnt_asid(mnt_asid),
    .mnt_done(mnt_done), .victim_idx(victim_idx)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Lookup: drive at a falling edge, sample at the next falling edge
  task automatic lookup(input logic [31:0] va, input logic [7:0] asid);
    @(negedge clk);
    lk_req  = 1'b1;
    lk_va   = va;
    lk_asid = asid;
    @(negedge clk);
    lk_req  = 1'b0;
  endtask

  task automatic expect_hit(input logic [31:0] va, input logic [7:0] asid,
                            input logic [3:0] slot, input logic [31:0] pa, input string tag);
    lookup(va, asid);
    check(lk_rsp_vld === 1'b1, {tag, " rsp_vld"}, 32'(lk_rsp_vld), 32'd1);
    check(lk_hit === 1'b1, {tag, " hit"}, 32'(lk_hit), 32'd1);
    check(lk_slot === slot, {tag, " slot"}, 32'(lk_slot), 32'(slot));
    check(lk_pa === pa, {tag, " pa"}, lk_pa, pa);
  endtask

  task automatic expect_miss(input logic [31:0] va, input logic [7:0] asid, input string tag);
    lookup(va, asid);
    check(lk_rsp_vld === 1'b1, {tag, " rsp_vld"}, 32'(lk_rsp_vld), 32'd1);
    check(lk_hit === 1'b0, {tag, " miss"}, 32'(lk_hit), 32'd0);
  endtask

  task automatic insert(input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic [7:0] asid, input logic [4:0] shift);
    @(negedge clk);
    ins_req   = 1'b1;
    ins_vpn   = vpn;
    ins_pfn   = pfn;
    ins_asid  = asid;
    ins_shift = shift;
    @(negedge clk);
    ins_req   = 1'b0;
  endtask

  task automatic flush(input logic [1:0] op, input logic [31:0] va, input logic [7:0] asid);
    @(negedge clk);
    mnt_req  = 1'b1;
    mnt_op   = op;
    mnt_va   = va;
    mnt_asid = asid;
    @(negedge clk);
    mnt_req  = 1'b0;
    check(mnt_done === 1'b1, "R10 done pulse", 32'(mnt_done), 32'd1);
  endtask

  task automatic check_ptr(input logic [3:0] exp, input string tag);
    check(victim_idx === exp, tag, 32'(victim_idx), 32'(exp));
  endtask

  // Scenarios
  task automatic t_reset();
    check(victim_idx === 4'd0, "R11 ptr after reset", 32'(victim_idx), 32'd0);
    check(lk_rsp_vld === 1'b0, "R11 rsp_vld after reset", 32'(lk_rsp_vld), 32'd0);
    check(lk_hit === 1'b0, "R11 hit after reset", 32'(lk_hit), 32'd0);
    check(mnt_done === 1'b0, "R11 done after reset", 32'(mnt_done), 32'd0);
    expect_miss(32'h1234_5678, 8'd1, "R11 empty lookup");
  endtask

  task automatic t_basic();
    insert(20'h12345, 20'hABCDE, 8'd1, 5'd12);
    insert(20'h04000, 20'h00077, 8'd2, 5'd16);
    insert(20'h12345, 20'h11111, 8'd3, 5'd12);
    check_ptr(4'd3, "R4 ptr after three inserts");
    expect_hit(32'h1234_5678, 8'd1, 4'd0, 32'hABCD_E678, "R1 R3 small page");
    check(lk_pfn === 20'hABCDE, "R3 pfn out", 32'(lk_pfn), 32'hABCDE);
    check(lk_shift === 5'd12, "R3 shift out", 32'(lk_shift), 32'd12);
    expect_hit(32'h4000_BEEF, 8'd2, 4'd1, 32'h0077_BEEF, "R3 large page");
    expect_hit(32'h1234_5678, 8'd3, 4'd2, 32'h1111_1678, "R1 tag selects");
    expect_miss(32'h1234_5678, 8'd5, "R1 tag mismatch");
    expect_miss(32'h1234_6678, 8'd1, "R1 page mismatch");
  endtask

  task automatic t_first_match();
    insert(20'h12345, 20'h22222, 8'd1, 5'd12);
    expect_hit(32'h1234_5ABC, 8'd1, 4'd0, 32'hABCD_EABC, "R2 lowest slot wins");
  endtask

  task automatic t_pointer();
    insert(20'h00050, 20'h00500, 8'd4, 5'd12);
    check_ptr(4'd5, "R4 ptr before fill");
    for (int i = 5; i < N; i++) begin
      insert(20'(20'h100 + i), 20'(20'h200 + i), 8'd7, 5'd12);
    end
    check_ptr(4'd0, "R4 ptr wraps");
    expect_hit(32'h1234_5000, 8'd1, 4'd0, 32'hABCD_E000, "R5 hit slot 0");
    check_ptr(4'd1, "R5 hit on pointer advances");
    expect_hit(32'h4000_0001, 8'd2, 4'd1, 32'h0077_0001, "R5 hit slot 1");
    check_ptr(4'd2, "R5 second advance");
    expect_miss(32'h9999_9000, 8'd7, "R5 miss");
    check_ptr(4'd2, "R5 miss holds ptr");
    expect_hit(32'h0005_0123, 8'd4, 4'd4, 32'h0050_0123, "R5 other slot");
    check_ptr(4'd2, "R5 other hit holds ptr");
    insert(20'h12345, 20'h33333, 8'd3, 5'd12);
    check_ptr(4'd3, "R4 overwrite advances");
    expect_hit(32'h1234_5678, 8'd3, 4'd2, 32'h3333_3678, "R4 valid slot overwritten");
  endtask

  task automatic t_flush_asid();
    flush(2'd1, 32'h0, 8'd1);
    expect_miss(32'h1234_5678, 8'd1, "R7 tag 1 gone");
    expect_hit(32'h1234_5678, 8'd3, 4'd2, 32'h3333_3678, "R7 tag 3 kept");
    expect_hit(32'h0010_7000, 8'd7, 4'd7, 32'h0020_7000, "R7 filler kept");
  endtask

  task automatic t_flush_addr();
    flush(2'd2, 32'h4000_F000, 8'h55);
    expect_miss(32'h4000_0010, 8'd2, "R8 large page removed");
    expect_hit(32'h0005_0ABC, 8'd4, 4'd4, 32'h0050_0ABC, "R8 other page kept");
    expect_hit(32'h1234_5004, 8'd3, 4'd2, 32'h3333_3004, "R8 unrelated kept");
  endtask

  task automatic t_flush_addr_asid();
    check_ptr(4'd3, "R9 ptr setup");
    insert(20'h77777, 20'h0AAAA, 8'd9, 5'd12);
    insert(20'h77777, 20'h0BBBB, 8'd9, 5'd12);
    insert(20'h77777, 20'h0CCCC, 8'd8, 5'd12);
    expect_hit(32'h7777_7ABC, 8'd9, 4'd3, 32'h0AAA_AABC, "R9 before flush");
    flush(2'd3, 32'h7777_7ABC, 8'd9);
    expect_miss(32'h7777_7ABC, 8'd9, "R9 all matches removed");
    expect_hit(32'h7777_7ABC, 8'd8, 4'd5, 32'h0CCC_CABC, "R9 other tag kept");
  endtask

  task automatic t_same_cycle();
    check_ptr(4'd6, "R10 ptr setup");
    @(negedge clk);
    lk_req  = 1'b1;
    lk_va   = 32'h7777_7001;
    lk_asid = 8'd8;
    mnt_req = 1'b1;
    mnt_op  = 2'd0;
    @(negedge clk);
    lk_req  = 1'b0;
    mnt_req = 1'b0;
    check(lk_hit === 1'b1, "R10 lookup sees old contents", 32'(lk_hit), 32'd1);
    check(lk_pa === 32'h0CCC_C001, "R10 old pa", lk_pa, 32'h0CCC_C001);
    check(mnt_done === 1'b1, "R10 done with lookup", 32'(mnt_done), 32'd1);
    check_ptr(4'd0, "R6 ptr cleared");
    @(negedge clk);
    check(mnt_done === 1'b0, "R10 done is one cycle", 32'(mnt_done), 32'd0);
    expect_miss(32'h7777_7001, 8'd8, "R6 entry gone");
    expect_miss(32'h0010_5000, 8'd7, "R6 filler gone");
    @(negedge clk);
    ins_req   = 1'b1;
    ins_vpn   = 20'h0ABCD;
    ins_pfn   = 20'h0DCBA;
    ins_asid  = 8'd6;
    ins_shift = 5'd12;
    mnt_req   = 1'b1;
    mnt_op    = 2'd1;
    mnt_asid  = 8'hEE;
    @(negedge clk);
    ins_req = 1'b0;
    mnt_req = 1'b0;
    check_ptr(4'd0, "R10 insert dropped ptr");
    expect_miss(32'h0ABC_D000, 8'd6, "R10 insert dropped entry");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    n_checks  = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    lk_req    = 1'b0;
    lk_va     = '0;
    lk_asid   = '0;
    ins_req   = 1'b0;
    ins_vpn   = '0;
    ins_pfn   = '0;
    ins_asid  = '0;
    ins_shift = '0;
    mnt_req   = 1'b0;
    mnt_op    = '0;
    mnt_va    = '0;
    mnt_asid  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_first_match();
    t_pointer();
    t_flush_asid();
    t_flush_addr();
    t_flush_addr_asid();
    t_same_cycle();
    finish_run();
  end

endmodule